// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This block moves the elements of one vector register into another under the control of a one-bit-per-element mask. In compress mode it walks the source vector and copies only the elements whose mask bit is set, packing them in their original order into the lowest destination slots. In expand mode it does the opposite. It takes source elements 0, 1, 2, ... in turn and drops each one into the next destination position whose mask bit is set. Every other destination position is left as it was.

An operation is launched with a single-cycle start pulse. The pulse carries the operation select, the active vector length and the mask. The unit then examines one element per clock. Source elements are fetched through an index/data read port whose data is expected back combinationally in the same cycle. Results leave through an index/data/enable write port. When the last active element has been examined, the unit raises a one-cycle done pulse. At the same moment it presents the packed length, which is the number of set mask bits inside the active length. That length stays on its output until the next operation finishes.

Top module: `vec_pack_unit`

## Requirements
- R1: After reset, busy, done and the destination write enable are low and the packed length reads 0.
- R2: With the operation select at 0 (compress), the k-th set mask bit in ascending element order causes source element at that position to be written to destination slot k, one write per set bit, in ascending slot order.
- R3: The done pulse is accompanied by a packed length equal to the number of set mask bits among elements 0 to vector length minus 1, and that value holds afterwards.
- R4: With the operation select at 1 (expand), the k-th set mask bit, at position p, causes source element k to be written to destination position p.
- R5: During expand, destination positions whose mask bit is clear receive no write and keep their previous contents.
- R6: Mask bits at element positions equal to or above the vector length have no effect on writes or on the packed length. A vector length above the element count is treated as the element count.
- R7: During compress, destination slots at and above the packed length receive no write and keep their previous contents.
- R8: The unit is busy for exactly vector-length cycles, examining element i in the i-th busy cycle. Done is a single-cycle pulse in the cycle right after the last busy cycle. A vector length of 0 gives done in the first cycle after start, with packed length 0.
- R9: A start pulse that arrives while the unit is busy is ignored, and the running operation completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch pulse, accepted only while idle |
| op_expand_i | input | 1 | 0 selects compress, 1 selects expand |
| vlen_i | input | LW | Active vector length, sampled with start |
| mask_i | input | ELEMS | One bit per element, sampled with start |
| src_rd_en_o | output | 1 | Source read strobe for the current element move |
| src_rd_idx_o | output | IW | Source element index |
| src_rd_data_i | input | DW | Source element data, same-cycle return |
| dst_wr_en_o | output | 1 | Destination write enable |
| dst_wr_idx_o | output | IW | Destination element index |
| dst_wr_data_o | output | DW | Destination element data |
| busy_o | output | 1 | High while elements are being scanned |
| done_o | output | 1 | One-cycle completion pulse |
| pack_len_o | output | LW | Packed length (mask population count) |

## Verification
Compress and expand are both run with a sparse, irregular mask (elements 1, 4, 5 and 7 set). This separates slot numbering from element numbering, so an index swapped between read and write ports shows up at once. An all-ones mask and an all-zeros mask probe the two extremes: every element moved, or nothing written while the full scan time is still spent. Short vector lengths under masks that have bits set beyond the length show whether out-of-range bits leak into writes or into the count, and a zero length checks the immediate-done path. A second start injected mid-operation with a different mode and mask checks that the running operation is left alone.

// File: rtl/vpk_pkg.sv
// Shared types for the vector mask compress/expand unit.
// Assumes nothing beyond a two-valued operation select.
package vpk_pkg;
    typedef enum logic {
        VPK_COMPRESS = 1'b0,
        VPK_EXPAND   = 1'b1
    } vpk_op_e;
endpackage

// File: rtl/vpk_popcount.sv
// Population count of a mask vector.
// Assumes CW is wide enough to hold N.
module vpk_popcount #(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits_i,
    output logic [CW-1:0] count_o
);
    // Sum the set bits one by one.
    always_comb begin
        count_o = '0;
        for (int i = 0; i < N; i++) begin
            count_o = count_o + CW'(bits_i[i]);
        end
    end
endmodule

// File: rtl/vpk_scan_ctrl.sv
// Scan sequencer: accepts a start while idle, steps an element index
// once per cycle for the active length, then emits a done pulse.
// Assumes ELEMS >= 2 and LW can hold ELEMS.
module vpk_scan_ctrl #(
    parameter int ELEMS = 8,
    parameter int LW    = $clog2(ELEMS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [LW-1:0] vlen_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          launch_o,
    output logic          empty_launch_o,
    output logic          last_o,
    output logic [LW-1:0] scan_idx_o,
    output logic [LW-1:0] vlen_eff_o
);
    logic [LW-1:0] vlen_q;

    // Clamp the requested length to the element count.
    assign vlen_eff_o     = (vlen_i > LW'(ELEMS)) ? LW'(ELEMS) : vlen_i;
    // A start counts only when the scanner is idle.
    assign launch_o       = start_i && !busy_o;
    assign empty_launch_o = launch_o && (vlen_eff_o == '0);
    // Final element of the current scan.
    assign last_o         = busy_o && (scan_idx_o == vlen_q - LW'(1));

    // Sequencer state: busy flag, element index, done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o     <= 1'b0;
            done_o     <= 1'b0;
            scan_idx_o <= '0;
            vlen_q     <= '0;
        end else begin
            done_o <= 1'b0;
            if (launch_o) begin
                vlen_q     <= vlen_eff_o;
                scan_idx_o <= '0;
                if (vlen_eff_o == '0) begin
                    done_o <= 1'b1;
                end else begin
                    busy_o <= 1'b1;
                end
            end else if (busy_o) begin
                if (last_o) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    scan_idx_o <= scan_idx_o + LW'(1);
                end
            end
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (done_o && !busy_o));

    // R9
    scan_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last_o) |=> (busy_o && scan_idx_o == $past(scan_idx_o) + LW'(1)));
endmodule

// File: rtl/vpk_lane_route.sv
// Element router: latches mode and in-range mask at launch, keeps the
// packed pointer, and steers read/write indices for compress or expand.
// Assumes the source read data returns in the same cycle as the index.
module vpk_lane_route
    import vpk_pkg::*;
#(
    parameter int ELEMS = 8,
    parameter int DW    = 16,
    parameter int IW    = $clog2(ELEMS),
    parameter int LW    = $clog2(ELEMS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_expand_i,
    input  logic [ELEMS-1:0] mask_i,
    input  logic [LW-1:0]    vlen_eff_i,
    input  logic             launch_i,
    input  logic             empty_launch_i,
    input  logic             busy_i,
    input  logic             last_i,
    input  logic             done_i,
    input  logic [LW-1:0]    scan_idx_i,
    input  logic [DW-1:0]    src_rd_data_i,
    output logic             src_rd_en_o,
    output logic [IW-1:0]    src_rd_idx_o,
    output logic             dst_wr_en_o,
    output logic [IW-1:0]    dst_wr_idx_o,
    output logic [DW-1:0]    dst_wr_data_o,
    output logic [LW-1:0]    pack_len_o
);
    vpk_op_e          op_q;
    logic [ELEMS-1:0] mask_q;
    logic [ELEMS-1:0] in_range;
    logic [LW-1:0]    ptr_q;
    logic [LW-1:0]    pop_cnt;
    logic             hit;

    // One range-compare per element position.
    for (genvar j = 0; j < ELEMS; j++) begin : g_range
        assign in_range[j] = (LW'(j) < vlen_eff_i);
    end

    // Independent count of the latched mask, used by the checks.
    vpk_popcount #(.N(ELEMS), .CW(LW)) u_pop (
        .bits_i  (mask_q),
        .count_o (pop_cnt)
    );

    // Current element is selected by the mask.
    assign hit = busy_i && mask_q[scan_idx_i[IW-1:0]];

    // Operation context and packed pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= VPK_COMPRESS;
            mask_q     <= '0;
            ptr_q      <= '0;
            pack_len_o <= '0;
        end else if (launch_i) begin
            op_q   <= op_expand_i ? VPK_EXPAND : VPK_COMPRESS;
            mask_q <= mask_i & in_range;
            ptr_q  <= '0;
            if (empty_launch_i) begin
                pack_len_o <= '0;
            end
        end else if (busy_i) begin
            if (hit) begin
                ptr_q <= ptr_q + LW'(1);
            end
            if (last_i) begin
                pack_len_o <= ptr_q + LW'(hit);
            end
        end
    end

    // Index steering: compress reads by scan and writes by pointer,
    // expand reads by pointer and writes by scan.
    always_comb begin
        src_rd_en_o   = hit;
        dst_wr_en_o   = hit;
        dst_wr_data_o = src_rd_data_i;
        if (op_q == VPK_COMPRESS) begin
            src_rd_idx_o = scan_idx_i[IW-1:0];
            dst_wr_idx_o = ptr_q[IW-1:0];
        end else begin
            src_rd_idx_o = ptr_q[IW-1:0];
            dst_wr_idx_o = scan_idx_i[IW-1:0];
        end
    end

    // R3
    pack_len_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> (pack_len_o == pop_cnt));

    // R2
    compress_no_overtake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op_q == VPK_COMPRESS) |-> (ptr_q <= scan_idx_i));

    // R7
    compress_below_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op_q == VPK_COMPRESS) |-> (ptr_q < pop_cnt));

    // R4
    expand_src_in_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op_q == VPK_EXPAND) |-> (ptr_q < pop_cnt));
endmodule

// File: rtl/vec_pack_unit.sv
// Top of the vector mask compress/expand unit: one element per cycle,
// done pulse with the packed length after the last active element.
// Assumes a combinational source read port.
module vec_pack_unit #(
    parameter int ELEMS = 8,
    parameter int DW    = 16,
    parameter int IW    = $clog2(ELEMS),
    parameter int LW    = $clog2(ELEMS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             op_expand_i,
    input  logic [LW-1:0]    vlen_i,
    input  logic [ELEMS-1:0] mask_i,
    output logic             src_rd_en_o,
    output logic [IW-1:0]    src_rd_idx_o,
    input  logic [DW-1:0]    src_rd_data_i,
    output logic             dst_wr_en_o,
    output logic [IW-1:0]    dst_wr_idx_o,
    output logic [DW-1:0]    dst_wr_data_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [LW-1:0]    pack_len_o
);
    logic          launch;
    logic          empty_launch;
    logic          last;
    logic [LW-1:0] scan_idx;
    logic [LW-1:0] vlen_eff;

    // Sequencing of the element scan.
    vpk_scan_ctrl #(.ELEMS(ELEMS), .LW(LW)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .vlen_i         (vlen_i),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .launch_o       (launch),
        .empty_launch_o (empty_launch),
        .last_o         (last),
        .scan_idx_o     (scan_idx),
        .vlen_eff_o     (vlen_eff)
    );

    // Element movement and packed length.
    vpk_lane_route #(.ELEMS(ELEMS), .DW(DW), .IW(IW), .LW(LW)) u_route (
        .clk            (clk),
        .rst_n          (rst_n),
        .op_expand_i    (op_expand_i),
        .mask_i         (mask_i),
        .vlen_eff_i     (vlen_eff),
        .launch_i       (launch),
        .empty_launch_i (empty_launch),
        .busy_i         (busy_o),
        .last_i         (last),
        .done_i         (done_o),
        .scan_idx_i     (scan_idx),
        .src_rd_data_i  (src_rd_data_i),
        .src_rd_en_o    (src_rd_en_o),
        .src_rd_idx_o   (src_rd_idx_o),
        .dst_wr_en_o    (dst_wr_en_o),
        .dst_wr_idx_o   (dst_wr_idx_o),
        .dst_wr_data_o  (dst_wr_data_o),
        .pack_len_o     (pack_len_o)
    );
endmodule

// File: tb/vec_pack_unit_bench.sv
`timescale 1ns/1ps
module vec_pack_unit_bench;
    localparam int ELEMS = 8;
    localparam int DW    = 16;
    localparam int IW    = 3;
    localparam int LW    = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start;
    logic             op_exp;
    logic [LW-1:0]    vlen;
    logic [ELEMS-1:0] mask;
    logic             src_rd_en;
    logic [IW-1:0]    src_rd_idx;
    logic [DW-1:0]    src_rd_data;
    logic             dst_wr_en;
    logic [IW-1:0]    dst_wr_idx;
    logic [DW-1:0]    dst_wr_data;
    logic             busy;
    logic             done;
    logic [LW-1:0]    pack_len;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [DW-1:0] src_mem [ELEMS];
    logic [DW-1:0] dst_mem [ELEMS];

    always #2 clk = ~clk;

    assign src_rd_data = src_mem[src_rd_idx];

    vec_pack_unit #(.ELEMS(ELEMS), .DW(DW), .IW(IW), .LW(LW)) u_vec_pack_unit (
        .clk (clk), .rst_n (rst_n), .start_i (start), .op_expand_i (op_exp),
        .vlen_i (vlen), .mask_i (mask),
        .src_rd_en_o (src_rd_en), .src_rd_idx_o (src_rd_idx), .src_rd_data_i (src_rd_data),
        .dst_wr_en_o (dst_wr_en), .dst_wr_idx_o (dst_wr_idx), .dst_wr_data_o (dst_wr_data),
        .busy_o (busy), .done_o (done), .pack_len_o (pack_len)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Runs one operation against a behavioural model; poke injects a second start mid-run.
    task automatic run_op(input bit op, input int vl, input logic [ELEMS-1:0] m,
                          input int seed, input bit poke, input string req);
        int ve;
        int k;
        int exp_len;
        int q_idx[$];
        int q_dat[$];
        bit pen[ELEMS];
        logic [DW-1:0] exp_dst[ELEMS];
        ve = (vl > ELEMS) ? ELEMS : vl;
        for (int j = 0; j < ELEMS; j++) begin
            src_mem[j] = DW'(16'h1000 * seed + 16'h0011 * j + 3);
            dst_mem[j] = DW'(16'hD000 + 16'h0010 * seed + j);
            exp_dst[j] = dst_mem[j];
            pen[j]     = 1'b0;
        end
        k = 0;
        for (int e = 0; e < ve; e++) begin
            if (m[e]) begin
                pen[e] = 1'b1;
                if (!op) begin
                    q_idx.push_back(k); q_dat.push_back(int'(src_mem[e]));
                    exp_dst[k] = src_mem[e];
                end else begin
                    q_idx.push_back(e); q_dat.push_back(int'(src_mem[k]));
                    exp_dst[e] = src_mem[k];
                end
                k++;
            end
        end
        exp_len = k;
        start = 1'b1; op_exp = op; vlen = LW'(vl); mask = m;
        @(negedge clk);
        start = 1'b0;
        for (int n = 1; n <= ve + 1; n++) begin
            bit expen;
            if (poke && n == 2) begin
                start = 1'b1; op_exp = ~op; mask = ~m; vlen = LW'(ELEMS);
            end
            if (poke && n == 3) start = 1'b0;
            expen = (n <= ve) ? pen[n-1] : 1'b0;
            chk(dst_wr_en == expen, req, "wr_en", int'(dst_wr_en), int'(expen));
            if (dst_wr_en && expen && q_idx.size() > 0) begin
                int ei;
                int ed;
                ei = q_idx.pop_front();
                ed = q_dat.pop_front();
                chk(int'(dst_wr_idx) == ei, req, "wr_idx", int'(dst_wr_idx), ei);
                chk(int'(dst_wr_data) == ed, req, "wr_data", int'(dst_wr_data), ed);
            end
            if (dst_wr_en) dst_mem[dst_wr_idx] = dst_wr_data;
            chk(busy == (n <= ve), "R8", "busy", int'(busy), int'(n <= ve));
            chk(done == (n == ve + 1), "R8", "done", int'(done), int'(n == ve + 1));
            if (n == ve + 1)
                chk(int'(pack_len) == exp_len, "R3", "pack_len", int'(pack_len), exp_len);
            if (n <= ve) @(negedge clk);
        end
        for (int j = 0; j < ELEMS; j++)
            chk(dst_mem[j] == exp_dst[j], req, "dst contents", int'(dst_mem[j]), int'(exp_dst[j]));
        start = 1'b0; op_exp = 1'b0; mask = '0; vlen = '0;
        @(negedge clk);
        chk(done == 1'b0, "R8", "done pulse width", int'(done), 0);
        chk(int'(pack_len) == exp_len, "R3", "pack_len hold", int'(pack_len), exp_len);
        chk(dst_wr_en == 1'b0, req, "idle write", int'(dst_wr_en), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; op_exp = 1'b0; vlen = '0; mask = '0;
        for (int j = 0; j < ELEMS; j++) begin
            src_mem[j] = '0; dst_mem[j] = '0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
        chk(done == 1'b0, "R1", "done", int'(done), 0);
        chk(dst_wr_en == 1'b0, "R1", "wr_en", int'(dst_wr_en), 0);
        chk(pack_len == '0, "R1", "pack_len", int'(pack_len), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 R7 sparse compress
        run_op(1'b0, 8, 8'b1011_0010, 1, 1'b0, "R2/R7");
        // R4 R5 sparse expand
        run_op(1'b1, 8, 8'b1011_0010, 2, 1'b0, "R4/R5");
        // R2 all ones, R7 all zeros
        run_op(1'b0, 8, 8'hFF, 3, 1'b0, "R2");
        run_op(1'b0, 8, 8'h00, 4, 1'b0, "R7");
        run_op(1'b1, 8, 8'h00, 5, 1'b0, "R5");
        // R6 bits beyond the length
        run_op(1'b0, 5, 8'hF0, 6, 1'b0, "R6");
        run_op(1'b1, 3, 8'hFA, 7, 1'b0, "R6");
        run_op(1'b0, 12, 8'h5A, 8, 1'b0, "R6");
        // R8 zero length
        run_op(1'b0, 0, 8'hFF, 9, 1'b0, "R8");
        // R9 start while busy
        run_op(1'b0, 8, 8'b0110_1001, 10, 1'b1, "R9");
        run_op(1'b1, 6, 8'b0010_0110, 11, 1'b1, "R9");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule